// File: doc/BRIEF.md
# Timer-Shared Parallel Port Multiplexer

This block is an 8-bit general-purpose port whose pins can be lent to a timer unit. Software controls it through a small register bus. The bus gives access to a data latch, a per-pin direction register and a one-bit mode control. On the pad side, the block drives an output level and an output enable for each pin, and it receives the pad level back. On the timer side, it takes compare levels and compare enables. It returns synchronized capture inputs and an event-counter input. The timer counters live outside this block.

The three low pins feed capture channels. Pins 4 to 6 can be taken over by dedicated compare channels. Pin 7 can be taken over by the shared compare channel 1, which may also take over any of pins 3 to 6. Pin 3 has two modes, chosen by the mode bit: a fifth compare output or a fourth capture input. In capture mode, a pin set as an output delivers its own latch writes to the capture channel. Pin 7 always feeds the event counter.

The register bus accepts every access in the cycle it is presented. It has no ready signal and never applies back-pressure. Read data returns one cycle later with a valid strobe. All other pins are plain levels.

Top module: `tpm_port`

## Requirements
- R1: A direction bit of 0 makes its pin an input (output enable low, unless a compare takes the pin). A direction bit of 1 drives the pin from the data latch with output enable high.
- R2: Reset clears every direction bit and the mode bit to 0, so all pins start as inputs. While reset is held, the data latch samples the pad level, and it keeps that value after reset ends.
- R3: A write to the data register updates the latch for all eight bits, including bits set as inputs. A pin switched to output later drives the last value written.
- R4: Register addresses are: 0 data, 1 direction, 2 mode (bit 0 is the pin 3 capture select, the other bits read 0), 3 reads as zero. Read data and its valid strobe appear the cycle after the read strobe. A data read returns the latch for output bits and the synchronized pad level for input bits.
- R5: Capture outputs ic_cap[0], ic_cap[1] and ic_cap[2] carry pins 2, 1 and 0. Each passes through a two-flop synchronizer, so a pad change set up before a clock edge appears after the second edge.
- R6: With mode bit 0, compare channels 2, 3, 4 and 5 (oc_en[0..3], levels oc_lvl[1..4]) take pins 6, 5, 4 and 3. An enabled channel replaces the latch as the pin level and forces the output enable high.
- R7: oc1_mask bit k hands pin 3+k to compare channel 1 (level oc_lvl[0]) and forces its output enable high. Channel 1 wins over a dedicated channel on the same pin.
- R8: With mode bit 1, pin 3 is capture input 4 on ic_cap[3], and compare channel 5 and oc1_mask[0] have no effect on pin 3. With mode bit 0, ic_cap[3] is held at 0.
- R9: With mode bit 1 and pin 3 set as an output, ic_cap[3] follows the pin 3 latch from the cycle after a data write, without the synchronizer delay.
- R10: evt_cnt_in carries the synchronized pin 7 pad level in every pin configuration: input, latch-driven output or compare-driven output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pad_in | input | 8 | Level seen at each pad |
| pad_out | output | 8 | Level driven to each pad |
| pad_oe | output | 8 | Output enable per pad |
| oc_lvl | input | 5 | Compare levels, bit 0 = channel 1 ... bit 4 = channel 5 |
| oc_en | input | 4 | Dedicated compare enables, bit 0 = channel 2 ... bit 3 = channel 5 |
| oc1_mask | input | 5 | Channel 1 pin select, bit k = pin 3+k |
| ic_cap | output | 4 | Capture inputs 1 to 4 toward the timer |
| evt_cnt_in | output | 1 | Event-counter input from pin 7 |

## Verification
The assertions assume that every pad driven by the block reads back its own driven level. They also assume that timer and pad inputs change only between clock edges, and that reset is held long enough for the latch to sample the pads. The bench models the pad as the driven value when output enable is high and as an external source otherwise. It changes all inputs on the falling edge. It never writes and reads in the same cycle, so the read-valid checks see one strobe at a time.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  localparam int PORT_W     = 8;
  localparam int NUM_OC     = 5;
  localparam int NUM_DED_OC = NUM_OC - 1;
  localparam int NUM_IC     = 4;
  localparam int OC1_FIRST  = 3;
  localparam int OC1_PINS   = PORT_W - OC1_FIRST;
  localparam int DUAL_PIN   = 3;
  localparam int EVT_PIN    = PORT_W - 1;
  localparam int ADDR_W     = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_DIR  = 2'd1,
    REG_MODE = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // Dedicated compare channel (1-based) owning a pin, 0 when none.
  function automatic int ded_oc_ch(input int pin);
    case (pin)
      3: ded_oc_ch = 5;
      4: ded_oc_ch = 4;
      5: ded_oc_ch = 3;
      6: ded_oc_ch = 2;
      default: ded_oc_ch = 0;
    endcase
  endfunction

  // Pin feeding capture channel ic (1-based).
  function automatic int ic_src_pin(input int ic);
    case (ic)
      1: ic_src_pin = 2;
      2: ic_src_pin = 1;
      3: ic_src_pin = 0;
      default: ic_src_pin = DUAL_PIN;
    endcase
  endfunction
endpackage

// File: rtl/tpm_in_sync.sv
module tpm_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= pad_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign pin_sync = stg[STAGES-1];
endmodule

// File: rtl/tpm_regs.sv
module tpm_regs
  import tpm_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  input  logic [W-1:0]      pad_in,
  input  logic [W-1:0]      pin_sync,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic              sel_q,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_rvalid
);
  reg_sel_e     sel;
  logic [W-1:0] rd_mux;

  assign sel = reg_sel_e'(bus_addr);

  // Latch has no reset value: it samples the pads while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n)
      latch_q <= pad_in;
    else if (bus_wr && sel == REG_DATA)
      latch_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      sel_q <= 1'b0;
    end else if (bus_wr) begin
      if (sel == REG_DIR)  dir_q <= bus_wdata;
      if (sel == REG_MODE) sel_q <= bus_wdata[0];
    end
  end

  always_comb begin
    case (sel)
      REG_DATA: rd_mux = (dir_q & latch_q) | (~dir_q & pin_sync);
      REG_DIR:  rd_mux = dir_q;
      REG_MODE: rd_mux = {{(W-1){1'b0}}, sel_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/tpm_pin_mux.sv
module tpm_pin_mux
  import tpm_pkg::*;
(
  input  logic [PORT_W-1:0]     latch_q,
  input  logic [PORT_W-1:0]     dir_q,
  input  logic                  sel_q,
  input  logic [NUM_OC-1:0]     oc_lvl,
  input  logic [NUM_DED_OC-1:0] oc_en,
  input  logic [OC1_PINS-1:0]   oc1_mask,
  output logic [PORT_W-1:0]     pad_out,
  output logic [PORT_W-1:0]     pad_oe
);
  for (genvar p = 0; p < PORT_W; p++) begin : g_pin
    if (p < OC1_FIRST) begin : g_plain
      assign pad_out[p] = latch_q[p];
      assign pad_oe[p]  = dir_q[p];
    end else begin : g_shared
      localparam int CH = ded_oc_ch(p);
      logic ded_on, ded_lvl, allow, m_on, act;

      if (CH >= 2) begin : g_ded
        assign ded_on  = oc_en[CH-2];
        assign ded_lvl = oc_lvl[CH-1];
      end else begin : g_noded
        assign ded_on  = 1'b0;
        assign ded_lvl = 1'b0;
      end

      if (p == DUAL_PIN) begin : g_dual
        assign allow = !sel_q;
      end else begin : g_fixed
        assign allow = 1'b1;
      end

      assign m_on       = oc1_mask[p-OC1_FIRST];
      assign act        = allow & (m_on | ded_on);
      assign pad_out[p] = act ? (m_on ? oc_lvl[0] : ded_lvl) : latch_q[p];
      assign pad_oe[p]  = dir_q[p] | act;
    end
  end
endmodule

// File: rtl/tpm_cap_route.sv
module tpm_cap_route
  import tpm_pkg::*;
(
  input  logic [DUAL_PIN:0]  sync_low,
  input  logic               dual_latch,
  input  logic               dual_dir,
  input  logic               sel_q,
  output logic [NUM_IC-1:0]  ic_cap
);
  for (genvar k = 0; k < NUM_IC; k++) begin : g_ic
    localparam int SRC = ic_src_pin(k + 1);
    if (SRC == DUAL_PIN) begin : g_dual
      // Output pin: take the latch directly so a write is seen at once.
      assign ic_cap[k] = sel_q & (dual_dir ? dual_latch : sync_low[SRC]);
    end else begin : g_fixed
      assign ic_cap[k] = sync_low[SRC];
    end
  end
endmodule

// File: rtl/tpm_port.sv
module tpm_port
  import tpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [PORT_W-1:0]     bus_wdata,
  output logic [PORT_W-1:0]     bus_rdata,
  output logic                  bus_rvalid,
  input  logic [PORT_W-1:0]     pad_in,
  output logic [PORT_W-1:0]     pad_out,
  output logic [PORT_W-1:0]     pad_oe,
  input  logic [NUM_OC-1:0]     oc_lvl,
  input  logic [NUM_DED_OC-1:0] oc_en,
  input  logic [OC1_PINS-1:0]   oc1_mask,
  output logic [NUM_IC-1:0]     ic_cap,
  output logic                  evt_cnt_in
);
  logic [PORT_W-1:0] pin_sync;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] dir_q;
  logic              sel_q;

  tpm_in_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .pin_sync (pin_sync)
  );

  tpm_regs #(.W(PORT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pad_in     (pad_in),
    .pin_sync   (pin_sync),
    .latch_q    (latch_q),
    .dir_q      (dir_q),
    .sel_q      (sel_q),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  tpm_pin_mux u_mux (
    .latch_q  (latch_q),
    .dir_q    (dir_q),
    .sel_q    (sel_q),
    .oc_lvl   (oc_lvl),
    .oc_en    (oc_en),
    .oc1_mask (oc1_mask),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  tpm_cap_route u_cap (
    .sync_low   (pin_sync[DUAL_PIN:0]),
    .dual_latch (latch_q[DUAL_PIN]),
    .dual_dir   (dir_q[DUAL_PIN]),
    .sel_q      (sel_q),
    .ic_cap     (ic_cap)
  );

  assign evt_cnt_in = pin_sync[EVT_PIN];
endmodule

// File: rtl/tpm_port_chk.sv
module tpm_port_chk
  import tpm_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [PORT_W-1:0]   bus_wdata,
  input logic                bus_rvalid,
  input logic [PORT_W-1:0]   pad_out,
  input logic [PORT_W-1:0]   pad_oe,
  input logic [NUM_OC-1:0]   oc_lvl,
  input logic [OC1_PINS-1:0] oc1_mask,
  input logic [NUM_IC-1:0]   ic_cap,
  input logic [PORT_W-1:0]   latch_q,
  input logic [PORT_W-1:0]   dir_q,
  input logic                sel_q
);
  p_low_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe[OC1_FIRST-1:0] == dir_q[OC1_FIRST-1:0]);

  p_dir_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (dir_q == '0 && !sel_q));

  p_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  p_rvalid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  p_pin7_oc1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    oc1_mask[OC1_PINS-1] |-> (pad_oe[EVT_PIN] && pad_out[EVT_PIN] == oc_lvl[0]));

  p_ic4_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> !ic_cap[NUM_IC-1]);

  p_dual_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !dir_q[DUAL_PIN]) |-> !pad_oe[DUAL_PIN]);

  p_ic4_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_DATA && sel_q && dir_q[DUAL_PIN]
      && bus_wdata[DUAL_PIN] != latch_q[DUAL_PIN])
    |=> ic_cap[NUM_IC-1] != $past(ic_cap[NUM_IC-1]));
endmodule

bind tpm_port tpm_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .oc_lvl     (oc_lvl),
  .oc1_mask   (oc1_mask),
  .ic_cap     (ic_cap),
  .latch_q    (latch_q),
  .dir_q      (dir_q),
  .sel_q      (sel_q)
);

// File: tb/tb_tpm_port.sv
module tb_tpm_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       bus_rvalid;
  logic [7:0] pad_in, pad_out, pad_oe, ext = 8'h5A;
  logic [4:0] oc_lvl = '0, oc1_mask = '0;
  logic [3:0] oc_en = '0, ic_cap;
  logic       evt_cnt_in;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  // Pad model: a driven pad reads back its own level.
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  tpm_port dut (.*);

  typedef struct packed {
    logic       sel;
    logic [7:0] dir, dat;
    logic [3:0] en;
    logic [4:0] msk, lvl;
    logic [7:0] exp_out, exp_oe;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 8'hFF, 8'hA5, 4'h0, 5'h00, 5'h00, 8'hA5, 8'hFF},
    '{1'b0, 8'h0F, 8'h3C, 4'h0, 5'h00, 5'h00, 8'h3C, 8'h0F},
    '{1'b0, 8'h00, 8'h00, 4'hF, 5'h00, 5'h1E, 8'h78, 8'h78},
    '{1'b0, 8'h00, 8'hFF, 4'h0, 5'h1F, 5'h00, 8'h07, 8'hF8},
    '{1'b0, 8'h00, 8'h00, 4'hF, 5'h14, 5'h01, 8'hA0, 8'hF8},
    '{1'b1, 8'h00, 8'h08, 4'hF, 5'h01, 5'h1F, 8'h78, 8'h70},
    '{1'b1, 8'h08, 8'h08, 4'h0, 5'h00, 5'h00, 8'h08, 8'h08}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic v;
    // R2: reset state and latch sampling of the pads.
    idle(4);
    chk("R2 oe in reset", pad_oe, 8'h00);
    rst_n = 1'b1;
    idle(1);
    chk("R2 oe after reset", pad_oe, 8'h00);
    rd(2'd1, d, v); chk("R2 dir reset", d, 8'h00);
    chk("R4 rvalid", {7'b0, v}, 8'h01);
    rd(2'd2, d, v); chk("R2 mode reset", d, 8'h00);
    ext = 8'h00;
    wr(2'd1, 8'hFF);
    chk("R2 latch kept pad level", pad_out, 8'h5A);

    // Table of configurations: R1, R6, R7, R8.
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      oc_en = VECS[i].en; oc1_mask = VECS[i].msk; oc_lvl = VECS[i].lvl;
      wr(2'd2, {7'b0, VECS[i].sel});
      wr(2'd1, VECS[i].dir);
      wr(2'd0, VECS[i].dat);
      chk($sformatf("R1/R6/R7/R8 vec%0d out", i), pad_out, VECS[i].exp_out);
      chk($sformatf("R1/R6/R7/R8 vec%0d oe", i), pad_oe, VECS[i].exp_oe);
    end
    oc_en = '0; oc1_mask = '0; oc_lvl = '0;
    wr(2'd2, 8'h00);

    // R3: latch written while pins are inputs.
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hC3);
    chk("R3 inputs not driven", pad_oe, 8'h00);
    wr(2'd1, 8'hFF);
    chk("R3 last written value driven", pad_out, 8'hC3);

    // R4: mixed readback, mode register and unused address.
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h06);
    ext = 8'hB0;
    idle(3);
    rd(2'd0, d, v); chk("R4 data readback", d, 8'hB6);
    wr(2'd2, 8'hFF);
    rd(2'd2, d, v); chk("R4 mode readback", d, 8'h01);
    rd(2'd3, d, v); chk("R4 unused address", d, 8'h00);
    wr(2'd2, 8'h00);

    // R5: capture mapping and two-edge latency.
    wr(2'd1, 8'h00);
    ext = 8'h00;
    idle(3);
    ext = 8'h01;
    @(negedge clk); chk("R5 after one edge", {4'b0, ic_cap}, 8'h00);
    @(negedge clk); chk("R5 pin0 to cap3", {4'b0, ic_cap}, 8'h04);
    ext = 8'h06;
    idle(3); chk("R5 pins1,2 to cap2,cap1", {4'b0, ic_cap}, 8'h03);

    // R8: pin 3 as capture input, then gated off.
    ext = 8'h08;
    wr(2'd2, 8'h01);
    idle(2); chk("R8 cap4 from pad", {7'b0, ic_cap[3]}, 8'h01);
    wr(2'd2, 8'h00);
    chk("R8 cap4 gated in compare mode", {7'b0, ic_cap[3]}, 8'h00);

    // R9: latch writes on output pin 3 reach capture 4 at once.
    ext = 8'h00;
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h08);
    idle(3);
    chk("R9 idle low", {7'b0, ic_cap[3]}, 8'h00);
    wr(2'd0, 8'h08);
    chk("R9 rising write", {7'b0, ic_cap[3]}, 8'h01);
    wr(2'd0, 8'h00);
    chk("R9 falling write", {7'b0, ic_cap[3]}, 8'h00);
    wr(2'd2, 8'h00);

    // R10: event input follows pin 7 in every configuration.
    wr(2'd1, 8'h00);
    ext = 8'h80;
    idle(3); chk("R10 input high", {7'b0, evt_cnt_in}, 8'h01);
    ext = 8'h00;
    idle(3); chk("R10 input low", {7'b0, evt_cnt_in}, 8'h00);
    wr(2'd0, 8'h80);
    wr(2'd1, 8'h80);
    idle(3); chk("R10 latch output", {7'b0, evt_cnt_in}, 8'h01);
    oc1_mask = 5'h10; oc_lvl = 5'h00;
    idle(3); chk("R10 compare output", {7'b0, evt_cnt_in}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule